// File: doc/BRIEF.md
# Serial Calibration Trim-DAC Array

This block models a bank of three eight-channel, eight-bit calibration trim converters that a host programs by toggling bits of a single 16-bit configuration word. Every write of the word can present a serial data bit, raise or lower a serial clock, and name one of the three converters in a two-bit load field. The serial clock is edge-detected against the previously written clock bit. Each rising edge shifts the data bit into an 11-bit frame register, most significant bit first. The frame holds a three-bit local channel address above an eight-bit code.

A write with a non-zero load field copies the frame's code into the addressed channel of the selected converter. All 24 held codes are presented continuously on a flat readback bus.

A separate combinational decoder translates a global calibration channel number into its converter, local channel and load code. It also reports whether the channel is an offset trim, a gain trim or the shared reference offset, which analog output it belongs to, and whether the channel exists for the configured number of outputs.

Top module: `cal_trim_array`

## Requirements
- R1: After reset every one of the 24 held codes reads 0x80, the frame register is empty and the remembered serial clock is low.
- R2: A write with cfg_wdata[1]=1 while the previously written cfg_wdata[1] was 0 shifts cfg_wdata[0] into the frame LSB. A frame is 11 bits sent MSB first: frame[10:8] is the local channel and frame[7:0] the code.
- R3: A write with cfg_wdata[1]=1 whose preceding write also had cfg_wdata[1]=1, and any write with cfg_wdata[1]=0, leaves the frame unchanged.
- R4: Only the 11 most recently shifted bits take part in a load; earlier bits are discarded.
- R5: A write with cfg_wdata[15:14]=k, k in 1..3, stores frame[7:0] into channel frame[10:8] of converter k-1, visible on the clock edge after the write; no other held code changes.
- R6: A write with cfg_wdata[15:14]=0 changes no held code.
- R7: cfg_wdata[13:2] affects neither the frame nor any held code.
- R8: A write that both raises the serial clock and carries a non-zero load field loads the frame as it was before that write, and also shifts that write's data bit in.
- R9: Converter c, channel n is read on codes_o[(c*8+n)*8 +: 8].
- R10: For cal_idx 0..23: map_chip = cal_idx>>3, map_local = cal_idx&7 and map_load = (cal_idx>>3)+1.
- R11: map_valid is 1 only for cal_idx < 2*NOUT+1 (21 by default). For idx<12, map_kind is 0 (offset) when idx is even and 1 (gain) when odd, with map_out=idx/2. idx 12 gives kind 2 (reference) and out 0. For valid idx>12, kind is (idx-13) odd ? 1 : 0 and out = 6+(idx-13)/2. Invalid idx gives kind 3 and out 0.
- R12: In a cycle without a write, neither held codes nor the frame change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 16 | Configuration word: data bit 0, clock bit 1, load field 15:14 |
| codes_o | output | 192 | All held codes, eight bits per channel |
| cal_idx | input | 5 | Global calibration channel to decode |
| map_valid | output | 1 | Channel exists for NOUT outputs |
| map_chip | output | 2 | Converter index |
| map_local | output | 3 | Local channel in converter |
| map_load | output | 2 | Load-field value selecting that converter |
| map_kind | output | 2 | 0 offset, 1 gain, 2 reference, 3 none |
| map_out | output | 4 | Analog output channel served |

## Verification
The load and the shift can fall in the same write. One word both raises the serial clock and names a converter, so the converter must take the frame as it stood before the write, while the new bit still enters the frame. The bench provokes this by opening a new frame with that combined write right after a complete frame. It then checks that the first frame's code lands in the named converter, and that the second frame, finished and loaded later, carries the bit from the combined write. Random traffic with mixed load fields and repeated clock-high writes also produces the collision, and every result is compared with a bench model.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef enum logic [1:0] {
    TRIM_OFFSET = 2'd0,
    TRIM_GAIN   = 2'd1,
    TRIM_REF    = 2'd2,
    TRIM_NONE   = 2'd3
  } trim_kind_e;
endpackage

// File: rtl/trim_serial_if.sv
// Serial front end: clock edge detect, frame shift register, load decode.
module trim_serial_if #(
  parameter int CFGW     = 16,
  parameter int CW       = 8,
  parameter int AW       = 3,
  parameter int NCHIP    = 3,
  parameter int LD_LSB   = 14,
  localparam int FRAME   = AW + CW,
  localparam int SELW    = $clog2(NCHIP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFGW-1:0]  cfg_wdata,
  output logic [FRAME-1:0] shift_q,
  output logic             sclk_q,
  output logic [NCHIP-1:0] ld_stb,
  output logic [AW-1:0]    ld_addr,
  output logic [CW-1:0]    ld_val
);
  localparam int SDAT_BIT = 0;
  localparam int SCLK_BIT = 1;

  logic             rise;
  logic [FRAME-1:0] shift_d;
  logic             sclk_d;
  logic [SELW-1:0]  sel;
  logic             unused_bits;

  assign unused_bits = ^cfg_wdata[LD_LSB-1:SCLK_BIT+1];

  // next state
  always_comb begin
    rise    = cfg_wdata[SCLK_BIT] & ~sclk_q;
    shift_d = shift_q;
    if (rise) shift_d = {shift_q[FRAME-2:0], cfg_wdata[SDAT_BIT]};
    sclk_d  = cfg_wdata[SCLK_BIT];
  end

  // registers, enabled by the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      sclk_q  <= 1'b0;
    end else if (cfg_we) begin
      shift_q <= shift_d;
      sclk_q  <= sclk_d;
    end
  end

  assign sel     = cfg_wdata[LD_LSB +: SELW];
  assign ld_addr = shift_q[FRAME-1:CW];
  assign ld_val  = shift_q[CW-1:0];

  for (genvar g = 0; g < NCHIP; g++) begin : g_stb
    assign ld_stb[g] = cfg_we && (sel == SELW'(g + 1));
  end
endmodule

// File: rtl/trim_chip.sv
// One trim converter: CH held codes, one written per load strobe.
module trim_chip #(
  parameter int           CH         = 8,
  parameter int           CW         = 8,
  parameter int           AW         = 3,
  parameter logic [CW-1:0] RESET_CODE = 8'h80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [AW-1:0]    addr,
  input  logic [CW-1:0]    val,
  output logic [CH*CW-1:0] codes
);
  for (genvar g = 0; g < CH; g++) begin : g_ch
    logic          hit;
    logic [CW-1:0] code_d;
    logic [CW-1:0] code_q;

    always_comb begin
      hit    = ld && (addr == AW'(g));
      code_d = val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   code_q <= RESET_CODE;
      else if (hit) code_q <= code_d;
    end

    assign codes[g*CW +: CW] = code_q;
  end
endmodule

// File: rtl/trim_chan_map.sv
// Global calibration channel number decoder (combinational).
module trim_chan_map
  import trim_pkg::*;
#(
  parameter int NOUT   = 10,
  parameter int PAIRS0 = 6,
  parameter int IDXW   = 5,
  parameter int AW     = 3,
  parameter int CHIPW  = 2,
  parameter int SELW   = 2,
  parameter int OUTW   = 4
) (
  input  logic [IDXW-1:0]  cal_idx,
  output logic             map_valid,
  output logic [CHIPW-1:0] map_chip,
  output logic [AW-1:0]    map_local,
  output logic [SELW-1:0]  map_load,
  output logic [1:0]       map_kind,
  output logic [OUTW-1:0]  map_out
);
  localparam int NVALID  = 2 * NOUT + 1;
  localparam int REF_IDX = 2 * PAIRS0;

  trim_kind_e kind;
  int         idx;
  int         rel;

  assign map_chip  = CHIPW'(cal_idx >> AW);
  assign map_local = cal_idx[AW-1:0];
  assign map_load  = SELW'(cal_idx >> AW) + SELW'(1);

  always_comb begin
    idx       = int'(cal_idx);
    rel       = idx - REF_IDX - 1;
    kind      = TRIM_NONE;
    map_out   = '0;
    map_valid = 1'b0;
    if (idx < NVALID) begin
      map_valid = 1'b1;
      if (idx < REF_IDX) begin
        kind    = idx[0] ? TRIM_GAIN : TRIM_OFFSET;
        map_out = OUTW'(idx / 2);
      end else if (idx == REF_IDX) begin
        kind    = TRIM_REF;
      end else begin
        kind    = rel[0] ? TRIM_GAIN : TRIM_OFFSET;
        map_out = OUTW'(PAIRS0 + rel / 2);
      end
    end
  end

  assign map_kind = kind;
endmodule

// File: rtl/cal_trim_array.sv
// Top: serial front end, converter bank and channel decoder.
module cal_trim_array #(
  parameter int            NOUT       = 10,
  parameter int            NCHIP      = 3,
  parameter int            CH         = 8,
  parameter int            CW         = 8,
  parameter int            CFGW       = 16,
  parameter int            LD_LSB     = 14,
  parameter int            PAIRS0     = 6,
  parameter logic [7:0]    RESET_CODE = 8'h80,
  localparam int AW    = $clog2(CH),
  localparam int IDXW  = $clog2(NCHIP * CH),
  localparam int CHIPW = $clog2(NCHIP),
  localparam int SELW  = $clog2(NCHIP + 1),
  localparam int OUTW  = $clog2(NOUT),
  localparam int FRAME = AW + CW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [CFGW-1:0]       cfg_wdata,
  output logic [NCHIP*CH*CW-1:0] codes_o,
  input  logic [IDXW-1:0]       cal_idx,
  output logic                  map_valid,
  output logic [CHIPW-1:0]      map_chip,
  output logic [AW-1:0]         map_local,
  output logic [SELW-1:0]       map_load,
  output logic [1:0]            map_kind,
  output logic [OUTW-1:0]       map_out
);
  logic             rst_meta;
  logic             rst_sync_n;
  logic [FRAME-1:0] shift_q;
  logic             sclk_q;
  logic [NCHIP-1:0] ld_stb;
  logic [AW-1:0]    ld_addr;
  logic [CW-1:0]    ld_val;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  trim_serial_if #(
    .CFGW(CFGW), .CW(CW), .AW(AW), .NCHIP(NCHIP), .LD_LSB(LD_LSB)
  ) u_serial (
    .clk(clk), .rst_n(rst_sync_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .shift_q(shift_q), .sclk_q(sclk_q), .ld_stb(ld_stb),
    .ld_addr(ld_addr), .ld_val(ld_val)
  );

  for (genvar c = 0; c < NCHIP; c++) begin : g_chip
    trim_chip #(
      .CH(CH), .CW(CW), .AW(AW), .RESET_CODE(RESET_CODE[CW-1:0])
    ) u_chip (
      .clk(clk), .rst_n(rst_sync_n), .ld(ld_stb[c]), .addr(ld_addr),
      .val(ld_val), .codes(codes_o[c*CH*CW +: CH*CW])
    );
  end

  trim_chan_map #(
    .NOUT(NOUT), .PAIRS0(PAIRS0), .IDXW(IDXW), .AW(AW),
    .CHIPW(CHIPW), .SELW(SELW), .OUTW(OUTW)
  ) u_map (
    .cal_idx(cal_idx), .map_valid(map_valid), .map_chip(map_chip),
    .map_local(map_local), .map_load(map_load), .map_kind(map_kind),
    .map_out(map_out)
  );
endmodule

// File: rtl/trim_chk.sv
// Property checker bound to cal_trim_array.
module trim_chk #(
  parameter int NCHIP  = 3,
  parameter int CH     = 8,
  parameter int CW     = 8,
  parameter int CFGW   = 16,
  parameter int LD_LSB = 14,
  parameter int NOUT   = 10,
  parameter int FRAME  = 11,
  parameter int IDXW   = 5,
  parameter int CHIPW  = 2,
  parameter int SELW   = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_we,
  input logic [CFGW-1:0]        cfg_wdata,
  input logic [FRAME-1:0]       shift_q,
  input logic                   sclk_q,
  input logic [NCHIP*CH*CW-1:0] codes_o,
  input logic [IDXW-1:0]        cal_idx,
  input logic                   map_valid,
  input logic [CHIPW-1:0]       map_chip,
  input logic [SELW-1:0]        map_load,
  input logic [1:0]             map_kind
);
  localparam int NSLOT = NCHIP * CH;

  logic [SELW-1:0]        fld;
  logic                   pend;
  int                     e_idx;
  logic [CW-1:0]          e_val;
  logic                   d_ok;
  logic [NSLOT*CW-1:0]    codes_d;
  logic [NSLOT-1:0]       chg;

  assign fld = cfg_wdata[LD_LSB +: SELW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      d_ok <= 1'b0;
    end else begin
      pend <= cfg_we && (fld != '0);
      d_ok <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    e_idx   <= (int'(fld) - 1) * CH + int'(shift_q[FRAME-1:CW]);
    e_val   <= shift_q[CW-1:0];
    codes_d <= codes_o;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_chg
    assign chg[s] = codes_o[s*CW +: CW] != codes_d[s*CW +: CW];
  end

  p_shift_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_wdata[1] && !sclk_q |=>
      shift_q == {$past(shift_q[FRAME-2:0]), $past(cfg_wdata[0])});

  p_no_reshift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && (sclk_q || !cfg_wdata[1]) |=> $stable(shift_q));

  p_load_val_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend && e_idx < NSLOT |-> codes_o[e_idx*CW +: CW] == e_val);

  p_one_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    d_ok |-> $countones(chg) <= 1);

  p_no_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && fld == '0 |=> $stable(codes_o));

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(codes_o) && $stable(shift_q));

  p_map_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    map_valid |-> int'(map_load) == int'(map_chip) + 1);

  p_map_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
    map_valid == (map_kind != 2'd3) && (int'(cal_idx) < 2 * NOUT + 1) == map_valid);
endmodule

bind cal_trim_array trim_chk #(
  .NCHIP(NCHIP), .CH(CH), .CW(CW), .CFGW(CFGW), .LD_LSB(LD_LSB),
  .NOUT(NOUT), .FRAME(FRAME), .IDXW(IDXW), .CHIPW(CHIPW), .SELW(SELW)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .shift_q(shift_q), .sclk_q(sclk_q), .codes_o(codes_o), .cal_idx(cal_idx),
  .map_valid(map_valid), .map_chip(map_chip), .map_load(map_load),
  .map_kind(map_kind)
);

// File: tb/tb_cal_trim_array.sv
`timescale 1ns/1ps
module tb_cal_trim_array;
  logic         clk;
  logic         rst_n;
  logic         cfg_we;
  logic [15:0]  cfg_wdata;
  logic [191:0] codes_o;
  logic [4:0]   cal_idx;
  logic         map_valid;
  logic [1:0]   map_chip;
  logic [2:0]   map_local;
  logic [1:0]   map_load;
  logic [1:0]   map_kind;
  logic [3:0]   map_out;

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0]  mcodes [24];
  logic [10:0] msr;
  logic        mprev;

  cal_trim_array dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .codes_o(codes_o), .cal_idx(cal_idx), .map_valid(map_valid),
    .map_chip(map_chip), .map_local(map_local), .map_load(map_load),
    .map_kind(map_kind), .map_out(map_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // one configuration write; model updated with pre-write state
  task automatic wr(input logic [15:0] w);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we    = 1'b0;
    if (w[15:14] != 2'd0)
      mcodes[(int'(w[15:14]) - 1) * 8 + int'(msr[10:8])] = msr[7:0];
    if (w[1] && !mprev) msr = {msr[9:0], w[0]};
    mprev = w[1];
  endtask

  function automatic logic [15:0] noise(input bit on);
    return on ? (16'($urandom) & 16'h3FFC) : 16'h0000;
  endfunction

  task automatic send_bits(input logic [10:0] bits, input int n, input bit nz, input bit rep);
    for (int b = n - 1; b >= 0; b--) begin
      wr(noise(nz) | {15'd0, bits[b]});
      wr(noise(nz) | 16'h0002 | {15'd0, bits[b]});
      if (rep) wr(noise(nz) | 16'h0002 | {15'd0, ~bits[b]});
    end
  endtask

  task automatic check_all(input string req);
    bit ok = 1'b1;
    int bad_i = 0;
    for (int i = 0; i < 24; i++)
      if (ok && codes_o[i*8 +: 8] !== mcodes[i]) begin ok = 1'b0; bad_i = i; end
    chk(ok, req, int'(codes_o[bad_i*8 +: 8]), int'(mcodes[bad_i]));
  endtask

  task automatic chk_byte(input int chip, input int ch, input logic [7:0] exp, input string req);
    chk(codes_o[(chip*8+ch)*8 +: 8] === exp, req, int'(codes_o[(chip*8+ch)*8 +: 8]), int'(exp));
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int seed;
    logic [15:0] hold;
    seed = int'($urandom(32'h00C0FFEE));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; cal_idx = '0;
    for (int i = 0; i < 24; i++) mcodes[i] = 8'h80;
    msr = '0; mprev = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R9 layout
    check_all("R1 reset codes");
    chk_byte(2, 7, 8'h80, "R1 R9 last slot");

    // R2 R5 R9: chip1 ch5 = A7
    send_bits({3'd5, 8'hA7}, 11, 1'b0, 1'b0);
    wr(16'h8000); wr(16'h0000);
    chk_byte(1, 5, 8'hA7, "R2 R5 R9 load chip1");
    check_all("R5 others unchanged");

    // R6: load field zero
    send_bits({3'd0, 8'h3C}, 11, 1'b0, 1'b0);
    wr(16'h0000); wr(16'h0000);
    check_all("R6 no-op field");
    chk_byte(0, 0, 8'h80, "R6 chip0 ch0 held");

    // R3: repeated clock-high writes with flipped data
    send_bits({3'd3, 8'h5A}, 11, 1'b0, 1'b1);
    wr(16'h4000); wr(16'h0000);
    chk_byte(0, 3, 8'h5A, "R3 no reshift");

    // R4: extra leading bits discarded
    send_bits(11'h7FF, 5, 1'b0, 1'b0);
    send_bits({3'd6, 8'h12}, 11, 1'b0, 1'b0);
    wr(16'hC000); wr(16'h0000);
    chk_byte(2, 6, 8'h12, "R4 last 11 bits");

    // R7: noise in bits 13:2
    send_bits({3'd1, 8'hE3}, 11, 1'b1, 1'b0);
    wr(16'h4000 | noise(1'b1)); wr(noise(1'b1));
    chk_byte(0, 1, 8'hE3, "R7 ignored bits");
    check_all("R7 model");

    // R8: load combined with rising clock of next frame
    send_bits({3'd2, 8'h11}, 11, 1'b0, 1'b0);
    wr(16'h0001);
    wr(16'hC003);
    chk_byte(2, 2, 8'h11, "R8 old frame loaded");
    send_bits({3'd4, 8'h95}, 10, 1'b0, 1'b0);
    wr(16'h4000); wr(16'h0000);
    chk_byte(0, 4, 8'h95, "R8 new bit kept");

    // R12: idle cycles
    hold = 16'h0;
    repeat (5) @(negedge clk);
    check_all("R12 idle hold");

    // random traffic
    for (int r = 0; r < 80; r++) begin
      logic [10:0] f;
      f = 11'($urandom);
      send_bits(f, 11, bit'($urandom % 2), bit'($urandom % 4 == 0));
      wr(16'($urandom % 4) << 14 | noise(bit'($urandom % 2)) | 16'($urandom % 4));
      wr(16'($urandom % 4) << 14 | noise(1'b1));
      check_all("R5 R8 random");
    end

    // R10 R11 decoder sweep
    for (int c = 0; c < 32; c++) begin
      int ek, eo;
      bit ev;
      @(negedge clk) cal_idx = 5'(c);
      #1;
      ev = c < 21;
      if (!ev) begin ek = 3; eo = 0; end
      else if (c < 12) begin ek = c % 2; eo = c / 2; end
      else if (c == 12) begin ek = 2; eo = 0; end
      else begin ek = (c - 13) % 2; eo = 6 + (c - 13) / 2; end
      if (c < 24) begin
        chk(int'(map_chip) == c / 8 && int'(map_local) == c % 8,
            "R10 chip/local", int'({map_chip, map_local}), c);
        chk(int'(map_load) == c / 8 + 1, "R10 load code", int'(map_load), c / 8 + 1);
      end
      chk(map_valid == ev, "R11 valid", int'(map_valid), int'(ev));
      chk(int'(map_kind) == ek && int'(map_out) == eo, "R11 kind/out",
          int'({map_kind, map_out}), ek * 16 + eo);
    end

    summary();
    $finish;
  end
endmodule